// File: doc/BRIEF.md
# Interrupt Grant and Vector Address Unit

This unit sits between a set of interrupting devices and a small CPU core. Each device raises a request on one of seven priority levels. The unit waits for the core to signal that an instruction has finished. At that boundary it picks the most urgent eligible request and asserts an acknowledge line toward that device. It then returns the address of the vector table entry that holds the start address of the service routine.

A per-level mode bit chooses how the vector is found. In device mode, the acknowledged device returns its own vector number. In level mode, the vector is the priority level plus 24. In both modes the table address is the vector times four. After it accepts a request, the unit takes no new interrupt until the core signals a return from the service routine.

The vector input from the device is a valid-only stream, and the acknowledge line acts as its ready signal. A vector presented while the acknowledge line is low is dropped. The address output is a single-cycle valid pulse with no back-pressure, because the core is expected to take it on the cycle it appears.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every acknowledge line is low, the address-valid output is low and the current priority level output reads 0.
- R2: A pending request is taken only on a cycle where the instruction-boundary strobe is high. Requests without the strobe cause no acknowledge.
- R3: The request line at bit i stands for level i+1, and level 7 is the most urgent. When several levels are pending, the highest one wins. Its acknowledge bit (bit level-1) rises on the cycle after the accepting edge, is the only acknowledge bit high, and stays steady until the address is produced.
- R4: When the mode bit of the winning level is 1 (level mode), the address is (level + 24) * 4, valid on the cycle after the acknowledge rises. For example, level 3 gives 0x6C and level 7 gives 0x7C.
- R5: When the mode bit is 0 (device mode), a vector that is valid while the acknowledge is high is captured. On the next cycle the address equals the vector times four, the valid output is high and the acknowledge is low.
- R6: In device mode, if no vector arrives during 16 cycles of acknowledge, the acknowledge drops after exactly 16 cycles and the address falls back to (level + 24) * 4.
- R7: On acceptance, the priority level output takes the accepted level. No further request is taken until the return input is seen after the address is produced. The return input sets the level output back to 0.
- R8: A vector presented while no acknowledge is high has no effect: no address-valid pulse follows.
- R9: The address-valid output is a one-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 7 | Request per level; bit i is level i+1 |
| irq_autovec | input | 7 | Per-level mode; 1 selects level-derived vector |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| vec_valid | input | 1 | Device vector valid; accepted only while acknowledge is high |
| vec_num | input | 8 | Vector number supplied by the device |
| irq_ret | input | 1 | Return/re-enable from the service routine |
| iack | output | 7 | One-hot acknowledge toward the granted level |
| tbl_valid | output | 1 | One-cycle pulse qualifying tbl_addr |
| tbl_addr | output | 10 | Byte address of the vector table entry |
| cur_mask | output | 3 | Level currently in service, 0 when idle |

## Verification
The bench uses the default parameters: seven levels, an 8-bit vector, a 16-cycle reply window and a level offset of 24. These defaults let the bench run the full fallback countdown in a few dozen cycles. They also let it drive vector 0xFF, which reaches the top entry of the 10-bit address. A behavioural model runs beside the design and is compared with it on every clock. The directed cases cover level ties, a strobe that is missing, late vectors and vectors that arrive while no acknowledge is high.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_HOLD = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLVL  = 7,
  parameter int LVL_W = 3
) (
  input  logic [NLVL-1:0]  req,
  input  logic [LVL_W-1:0] mask,
  output logic [LVL_W-1:0] win_lvl,
  output logic             win_any
);
  // Scan from low to high so the highest eligible level is the last one written.
  always_comb begin
    win_lvl = '0;
    win_any = 1'b0;
    for (int i = 0; i < NLVL; i++) begin
      if (req[i] && (LVL_W'(i + 1) > mask)) begin
        win_lvl = LVL_W'(i + 1);
        win_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  localparam int ADDR_W   = VEC_W + 2
) (
  input  logic              use_auto,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [VEC_W-1:0]  dev_vec,
  output logic [ADDR_W-1:0] addr
);
  logic [VEC_W-1:0] vec_sel;

  always_comb begin
    if (use_auto) vec_sel = VEC_W'(lvl) + VEC_W'(AUTO_BASE);
    else          vec_sel = dev_vec;
    addr = {vec_sel, 2'b00};
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_vec_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int TIMEOUT = 16,
  localparam int CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             win_any,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             win_auto,
  input  logic             vec_valid,
  input  logic             irq_ret,
  output ack_state_e       state,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W-1:0] mask_q,
  output logic             cap_now,
  output logic             cap_auto
);
  logic             auto_q;
  logic [CNT_W-1:0] wait_cnt;

  always_comb begin
    cap_now  = 1'b0;
    cap_auto = auto_q;
    if (state == ST_ACK) begin
      if (auto_q) begin
        cap_now = 1'b1;
      end else if (vec_valid) begin
        cap_now = 1'b1;
      end else if (wait_cnt == CNT_W'(TIMEOUT - 1)) begin
        cap_now  = 1'b1;
        cap_auto = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lvl_q    <= '0;
      mask_q   <= '0;
      auto_q   <= 1'b0;
      wait_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (insn_done && win_any) begin
            lvl_q    <= win_lvl;
            mask_q   <= win_lvl;
            auto_q   <= win_auto;
            wait_cnt <= '0;
            state    <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (cap_now) state <= ST_HOLD;
          else         wait_cnt <= wait_cnt + 1'b1;
        end
        ST_HOLD: begin
          if (irq_ret) begin
            mask_q <= '0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NLVL      = 7,
  parameter int VEC_W     = 8,
  parameter int TIMEOUT   = 16,
  parameter int AUTO_BASE = 24,
  localparam int LVL_W    = $clog2(NLVL + 1),
  localparam int ADDR_W   = VEC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   irq_req,
  input  logic [NLVL-1:0]   irq_autovec,
  input  logic              insn_done,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              irq_ret,
  output logic [NLVL-1:0]   iack,
  output logic              tbl_valid,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [LVL_W-1:0]  cur_mask
);
  logic [LVL_W-1:0]  win_lvl;
  logic              win_any;
  logic              win_auto;
  ack_state_e        state;
  logic [LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]  mask_q;
  logic              cap_now;
  logic              cap_auto;
  logic [ADDR_W-1:0] addr_d;

  irq_prio_pick #(.NLVL(NLVL), .LVL_W(LVL_W)) u_pick (
    .req     (irq_req),
    .mask    (mask_q),
    .win_lvl (win_lvl),
    .win_any (win_any)
  );

  always_comb begin
    win_auto = 1'b0;
    for (int i = 0; i < NLVL; i++) begin
      if (win_lvl == LVL_W'(i + 1)) win_auto = irq_autovec[i];
    end
  end

  irq_ack_fsm #(.LVL_W(LVL_W), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .win_any   (win_any),
    .win_lvl   (win_lvl),
    .win_auto  (win_auto),
    .vec_valid (vec_valid),
    .irq_ret   (irq_ret),
    .state     (state),
    .lvl_q     (lvl_q),
    .mask_q    (mask_q),
    .cap_now   (cap_now),
    .cap_auto  (cap_auto)
  );

  irq_vec_addr #(.LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)) u_addr (
    .use_auto (cap_auto),
    .lvl      (lvl_q),
    .dev_vec  (vec_num),
    .addr     (addr_d)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_iack
    assign iack[g] = (state == ST_ACK) && (lvl_q == LVL_W'(g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_valid <= 1'b0;
      tbl_addr  <= '0;
    end else begin
      tbl_valid <= cap_now;
      if (cap_now) tbl_addr <= addr_d;
    end
  end

  assign cur_mask = mask_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NLVL  = 7,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic [NLVL-1:0]  iack,
  input logic             tbl_valid,
  input logic [LVL_W-1:0] cur_mask
);
  a_r3_iack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iack));

  a_r3_iack_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((|iack) && $past(|iack)) |-> (iack == $past(iack)));

  a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|iack) |-> $past(insn_done));

  a_r5_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid |-> !(|iack));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid |=> !tbl_valid);

  a_r7_level_matches_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|iack) |-> (iack == (NLVL'(1) << (cur_mask - 1'b1))));

  a_r7_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|iack) |=> !(|iack));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NLVL(NLVL), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_done (insn_done),
  .iack      (iack),
  .tbl_valid (tbl_valid),
  .cur_mask  (cur_mask)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_req = '0;
  logic [6:0] irq_autovec = '0;
  logic       insn_done = 1'b0;
  logic       vec_valid = 1'b0;
  logic [7:0] vec_num = '0;
  logic       irq_ret = 1'b0;
  logic [6:0] iack;
  logic       tbl_valid;
  logic [9:0] tbl_addr;
  logic [2:0] cur_mask;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_autovec(irq_autovec),
    .insn_done(insn_done), .vec_valid(vec_valid), .vec_num(vec_num),
    .irq_ret(irq_ret), .iack(iack), .tbl_valid(tbl_valid),
    .tbl_addr(tbl_addr), .cur_mask(cur_mask)
  );

  // Behavioural reference: 0 idle, 1 acknowledging, 2 in service
  int m_phase = 0, m_lvl = 0, m_mask = 0, m_wait = 0;
  bit m_auto = 0, m_valid = 0;
  int m_addr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_lvl = 0; m_mask = 0; m_wait = 0; m_valid = 0; m_addr = 0;
    end else begin
      m_valid = 0;
      if (m_phase == 0) begin
        if (insn_done) begin
          for (int l = 7; l >= 1; l--) begin
            if (m_phase == 0 && irq_req[l-1] && l > m_mask) begin
              m_phase = 1; m_lvl = l; m_mask = l; m_wait = 0; m_auto = irq_autovec[l-1];
            end
          end
        end
      end else if (m_phase == 1) begin
        if (m_auto || m_wait == 15) begin
          m_addr = (m_lvl + 24) * 4; m_valid = 1; m_phase = 2;
        end else if (vec_valid) begin
          m_addr = vec_num * 4; m_valid = 1; m_phase = 2;
        end else m_wait++;
      end else if (irq_ret) begin
        m_mask = 0; m_phase = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 iack vs model", iack, (m_phase == 1) ? (1 << (m_lvl - 1)) : 0);
      check("R9 valid vs model", tbl_valid, m_valid);
      check("R7 level vs model", cur_mask, m_mask);
      if (m_valid) check("R4 address vs model", tbl_addr, m_addr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ret_pulse();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0; tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R1 iack in reset", iack, 0);
    check("R1 valid in reset", tbl_valid, 0);
    check("R1 level in reset", cur_mask, 0);
    rst_n = 1'b1;
    tick();
    check("R1 iack after reset", iack, 0);

    // R2: requests without boundary strobe
    irq_req = 7'b0000100; irq_autovec = 7'b1111111;
    repeat (3) tick();
    check("R2 no grant without strobe", iack, 0);
    // R8: vector while no acknowledge
    vec_num = 8'h33; vec_valid = 1'b1; tick(); vec_valid = 1'b0;
    tick();
    check("R8 stray vector ignored", tbl_valid, 0);

    // R4: level mode, level 3
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    check("R3 grant level 3", iack, 7'b0000100);
    check("R7 level shows 3", cur_mask, 3);
    tick();
    check("R4 valid level 3", tbl_valid, 1);
    check("R4 address level 3", tbl_addr, 10'h06C);
    tick();
    check("R9 pulse ends", tbl_valid, 0);

    // R7: blocked until return
    irq_req = 7'b1000100; insn_done = 1'b1;
    repeat (3) tick();
    check("R7 no grant while in service", iack, 0);
    check("R7 level held", cur_mask, 3);
    insn_done = 1'b0;
    ret_pulse();
    check("R7 level cleared by return", cur_mask, 0);
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    check("R3 highest level wins", iack, 7'b1000000);
    tick();
    check("R4 address level 7", tbl_addr, 10'h07C);
    ret_pulse();

    // R5: device mode, levels 2,5,6 pending
    irq_req = 7'b0110010; irq_autovec = 7'b0000000;
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    check("R3 grant level 6", iack, 7'b0100000);
    repeat (2) tick();
    check("R5 iack held awaiting vector", iack, 7'b0100000);
    vec_num = 8'h40; vec_valid = 1'b1; tick(); vec_valid = 1'b0;
    check("R5 valid after vector", tbl_valid, 1);
    check("R5 address from vector", tbl_addr, 10'h100);
    check("R5 iack released", iack, 0);
    ret_pulse();

    irq_req = 7'b0000010;
    insn_done = 1'b1; tick(); insn_done = 1'b0;
    vec_num = 8'hFF; vec_valid = 1'b1; tick(); vec_valid = 1'b0;
    check("R5 top vector address", tbl_addr, 10'h3FC);
    ret_pulse();

    // R6: no vector, fallback after 16 cycles
    irq_req = 7'b0000001;
    insn_done = 1'b1; tick(); insn_done = 1'b0; irq_req = '0;
    begin
      int n = 0;
      while (iack != 0 && n < 40) begin n++; tick(); end
      check("R6 acknowledge length", n, 16);
    end
    check("R6 fallback valid", tbl_valid, 1);
    check("R6 fallback address", tbl_addr, 100);
    ret_pulse();
    repeat (3) tick();
    check("R9 no further pulse", tbl_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule